// File: doc/BRIEF.md
# Forward Command/Data Byte Framer

This block merges two host-side byte queues into one outgoing stream for the forward direction of a parallel peripheral link. One queue takes command bytes and the other takes ordinary data bytes. Each byte leaves with a tag bit: the tag is high for data and low for a command, and it maps onto the host acknowledge level of the link. A command byte carries a channel address when its top bit is set. When the top bit is clear, the lower seven bits are a run-length count. To send a compressed run, the host writes the count as a command and then writes the byte to repeat as data.

Bytes leave in the order the host wrote them across both queues. A single ordering FIFO of one-bit tags records that order, and its depth is the sum of the two byte queue depths. The output uses a valid/ready handshake in place of the physical strobe and busy exchange. A run-length command written while the link mode is not the extended-capability setting is illegal: it is rejected at the write and is never sent. A write that reaches a full queue is dropped and sets a sticky overflow flag.

Top module: `ecp_fwd_framer`

## Requirements
- R1: A data byte is presented with `out_is_data` = 1. A command byte is presented with `out_is_data` = 0.
- R2: Bytes leave in the order they were accepted across both queues. When a command write and a data write are accepted in the same cycle, the command leaves first.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_byte`, `out_is_data` and `out_chan` hold their values into the next cycle.
- R4: A command with bit 7 = 0 (run-length count) is accepted only when `mode` equals 3'b011. Otherwise it is dropped and never presented, and `rle_reject` is 1 for exactly the one cycle after the write edge. Such a rejection does not set `overflow`.
- R5: A command with bit 7 = 1 (channel address) is accepted in every `mode` value.
- R6: `dat_full` (or `cmd_full`) is 1 while the data (or command) queue holds DAT_DEPTH (or CMD_DEPTH) bytes. A write to a full queue is dropped and never presented.
- R7: `overflow` becomes 1 on the edge that drops a write to a full queue. It then stays 1 until reset, even after the queues drain.
- R8: After reset, `out_valid`, `cmd_full`, `dat_full`, `overflow` and `rle_reject` are all 0.
- R9: `out_valid` is 0 when both queues are empty. Each handshake (`out_valid` and `out_ready` both 1 at an edge) removes exactly one byte.
- R10: `out_chan` is 1 exactly when the presented byte is a command with bit 7 = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Link mode; 3'b011 permits run-length commands |
| cmd_wr | input | 1 | Write strobe for the command queue |
| cmd_byte | input | 8 | Command byte: bit 7 selects channel address (1) or run-length count (0) |
| dat_wr | input | 1 | Write strobe for the data queue |
| dat_byte | input | 8 | Data byte |
| cmd_full | output | 1 | Command queue is full |
| dat_full | output | 1 | Data queue is full |
| overflow | output | 1 | Sticky: a write was dropped because its queue was full |
| rle_reject | output | 1 | One-cycle pulse: a run-length command was refused in a non-ECP mode |
| out_valid | output | 1 | A byte is presented |
| out_byte | output | 8 | Presented byte |
| out_is_data | output | 1 | Tag: 1 = data, 0 = command |
| out_chan | output | 1 | Presented byte is a channel-address command |
| out_ready | input | 1 | Downstream accepts the presented byte |

## Verification
Two things can happen in the same cycle: a command write and a data write, which both enter the ordering FIFO at one edge. The bench raises both strobes together while the output is stalled, then releases it. The scoreboard must see the command before the data. Separately, a run-length command can be refused while a channel address is accepted around it. The bench checks that the refused byte never reaches the output and that `rle_reject` pulses for exactly one cycle.

// File: rtl/ecp_fwd_pkg.sv
package ecp_fwd_pkg;
   localparam logic [2:0] MODE_EXT_CAP = 3'b011;

   typedef enum logic {
      TAG_CMD  = 1'b0,
      TAG_DATA = 1'b1
   } byte_tag_e;
endpackage

// File: rtl/ecp_byte_fifo.sv
module ecp_byte_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             pop,
   output logic [WIDTH-1:0] rd_data,
   output logic             empty,
   output logic             full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ecp_byte_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("ecp_byte_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    cnt;

   if (POW2) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   assign rd_data = mem[rd_ptr];
   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));

   AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) !(push && full && !pop)); // R6
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) !(pop && empty));         // R9
endmodule

// File: rtl/ecp_order_fifo.sv
module ecp_order_fifo #(
   parameter int DEPTH = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push_cmd,
   input  logic push_dat,
   input  logic pop,
   output logic head_is_data,
   output logic empty
);
   import ecp_fwd_pkg::*;

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ecp_order_fifo: DEPTH must be at least 2");
   end

   logic [DEPTH-1:0] tags;
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_p1, wr_p2, rd_p1;
   logic [CW-1:0]    cnt, cnt_nxt;
   logic [1:0]       n_push;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
      logic [AW:0] s;
      s = {1'b0, p} + (AW+1)'(1);
      if (s >= (AW+1)'(DEPTH)) s = s - (AW+1)'(DEPTH);
      return s[AW-1:0];
   endfunction

   assign wr_p1  = step(wr_ptr);
   assign wr_p2  = step(wr_p1);
   assign rd_p1  = step(rd_ptr);
   assign n_push = {1'b0, push_cmd} + {1'b0, push_dat};
   assign cnt_nxt = cnt + CW'(n_push) - CW'(pop);

   // Command goes in first when both arrive together.
   always_ff @(posedge clk) begin
      if (push_cmd) tags[wr_ptr] <= TAG_CMD;
      if (push_dat) tags[push_cmd ? wr_p1 : wr_ptr] <= TAG_DATA;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         case (n_push)
            2'd2:    wr_ptr <= wr_p2;
            2'd1:    wr_ptr <= wr_p1;
            default: wr_ptr <= wr_ptr;
         endcase
         if (pop) rd_ptr <= rd_p1;
         cnt <= cnt_nxt;
      end
   end

   assign head_is_data = tags[rd_ptr];
   assign empty        = (cnt == '0);

   AST_ORD_ROOM:   assert property (@(posedge clk) disable iff (!rst_n) ({1'b0, cnt} + {{CW{1'b0}}, 1'b0} + (CW+1)'(n_push)) <= (CW+1)'(DEPTH) + (CW+1)'(pop)); // R2
   AST_ORD_NO_UFL: assert property (@(posedge clk) disable iff (!rst_n) !(pop && empty)); // R9
endmodule

// File: rtl/ecp_cmd_screen.sv
module ecp_cmd_screen (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode,
   input  logic       cmd_wr,
   input  logic [7:0] cmd_byte,
   input  logic       q_full,
   output logic       cmd_push,
   output logic       cmd_drop_full,
   output logic       rle_reject
);
   import ecp_fwd_pkg::*;

   logic is_rle, rle_ok, legal;

   assign is_rle = ~cmd_byte[7];
   assign rle_ok = (mode == MODE_EXT_CAP);
   assign legal  = !is_rle || rle_ok;

   assign cmd_push      = cmd_wr && legal && !q_full;
   assign cmd_drop_full = cmd_wr && legal && q_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rle_reject <= 1'b0;
      else        rle_reject <= cmd_wr && !legal;
   end

   AST_RLE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n) (cmd_wr && !cmd_byte[7] && mode != MODE_EXT_CAP) |=> rle_reject); // R4
   AST_CHAN_ANY:    assert property (@(posedge clk) disable iff (!rst_n) (cmd_wr && cmd_byte[7] && !q_full) |-> cmd_push); // R5
endmodule

// File: rtl/ecp_fwd_framer.sv
module ecp_fwd_framer #(
   parameter int CMD_DEPTH = 8,
   parameter int DAT_DEPTH = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode,
   input  logic       cmd_wr,
   input  logic [7:0] cmd_byte,
   input  logic       dat_wr,
   input  logic [7:0] dat_byte,
   output logic       cmd_full,
   output logic       dat_full,
   output logic       overflow,
   output logic       rle_reject,
   output logic       out_valid,
   output logic [7:0] out_byte,
   output logic       out_is_data,
   output logic       out_chan,
   input  logic       out_ready
);
   localparam int ORD_DEPTH = CMD_DEPTH + DAT_DEPTH;

   logic       cmd_push, cmd_drop_full, dat_push, dat_drop;
   logic       cmd_pop, dat_pop, handshake;
   logic       cmd_empty, dat_empty, ord_empty, head_is_data;
   logic [7:0] cmd_head, dat_head;
   logic       ovf_q;

   ecp_cmd_screen i_screen (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode          (mode),
      .cmd_wr        (cmd_wr),
      .cmd_byte      (cmd_byte),
      .q_full        (cmd_full),
      .cmd_push      (cmd_push),
      .cmd_drop_full (cmd_drop_full),
      .rle_reject    (rle_reject)
   );

   assign dat_push = dat_wr && !dat_full;
   assign dat_drop = dat_wr && dat_full;

   ecp_byte_fifo #(.WIDTH(8), .DEPTH(CMD_DEPTH)) i_cmd_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (cmd_push),
      .wr_data (cmd_byte),
      .pop     (cmd_pop),
      .rd_data (cmd_head),
      .empty   (cmd_empty),
      .full    (cmd_full)
   );

   ecp_byte_fifo #(.WIDTH(8), .DEPTH(DAT_DEPTH)) i_dat_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (dat_push),
      .wr_data (dat_byte),
      .pop     (dat_pop),
      .rd_data (dat_head),
      .empty   (dat_empty),
      .full    (dat_full)
   );

   ecp_order_fifo #(.DEPTH(ORD_DEPTH)) i_order (
      .clk          (clk),
      .rst_n        (rst_n),
      .push_cmd     (cmd_push),
      .push_dat     (dat_push),
      .pop          (handshake),
      .head_is_data (head_is_data),
      .empty        (ord_empty)
   );

   assign out_valid   = !ord_empty;
   assign out_is_data = head_is_data;
   assign out_byte    = head_is_data ? dat_head : cmd_head;
   assign out_chan    = out_valid && !head_is_data && cmd_head[7];
   assign handshake   = out_valid && out_ready;
   assign cmd_pop     = handshake && !head_is_data;
   assign dat_pop     = handshake && head_is_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q <= 1'b0;
      else        ovf_q <= ovf_q | cmd_drop_full | dat_drop;
   end
   assign overflow = ovf_q;

   AST_TAG_CMD:    assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_is_data) |-> !cmd_empty); // R1
   AST_TAG_DATA:   assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_is_data) |-> !dat_empty);  // R1
   AST_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_is_data) && $stable(out_chan))); // R3
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow); // R7
   AST_OVF_SET:    assert property (@(posedge clk) disable iff (!rst_n) (dat_wr && dat_full) |=> overflow); // R7
   AST_IDLE:       assert property (@(posedge clk) disable iff (!rst_n) (cmd_empty && dat_empty) |-> !out_valid); // R9
endmodule

// File: tb/test_ecp_fwd_framer.sv
module test_ecp_fwd_framer;
   localparam int CLK_PERIOD = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode = 3'b011;
   logic       cmd_wr = 1'b0, dat_wr = 1'b0, out_ready = 1'b0;
   logic [7:0] cmd_byte = '0, dat_byte = '0;
   logic       cmd_full, dat_full, overflow, rle_reject;
   logic       out_valid, out_is_data, out_chan;
   logic [7:0] out_byte;

   int tests = 0, fails = 0;
   int ready_mode = 0;
   logic [9:0] sb[$];
   logic [7:0] lfsr = 8'hA5;

   always #(CLK_PERIOD/2) clk = ~clk;

   ecp_fwd_framer i_ecp_fwd_framer (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .cmd_wr(cmd_wr), .cmd_byte(cmd_byte), .dat_wr(dat_wr), .dat_byte(dat_byte),
      .cmd_full(cmd_full), .dat_full(dat_full), .overflow(overflow), .rle_reject(rle_reject),
      .out_valid(out_valid), .out_byte(out_byte), .out_is_data(out_is_data),
      .out_chan(out_chan), .out_ready(out_ready)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [9:0] item(input bit is_data, input logic [7:0] b);
      return {is_data, (!is_data && b[7]), b};
   endfunction

   // ready driver
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (ready_mode)
         0: out_ready = 1'b0;
         1: out_ready = 1'b1;
         default: out_ready = lfsr[0];
      endcase
   end

   // monitor / scoreboard: R1 tag, R2 order, R10 channel flag
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (sb.size() == 0) begin
            tests++; fails++;
            $display("FAIL R9: unexpected byte %0h tag %0b, expected none", out_byte, out_is_data);
         end else begin
            check("R1/R2/R10 stream", {22'd0, out_is_data, out_chan, out_byte}, {22'd0, sb[0]});
            void'(sb.pop_front());
         end
      end
   end

   task automatic wr(input bit is_data, input logic [7:0] b, input bit exp, input bit wait_room);
      @(posedge clk); #1;
      while (wait_room && (is_data ? dat_full : cmd_full)) begin @(posedge clk); #1; end
      if (is_data) begin dat_wr = 1'b1; dat_byte = b; end
      else         begin cmd_wr = 1'b1; cmd_byte = b; end
      if (exp) sb.push_back(item(is_data, b));
      @(posedge clk); #1;
      cmd_wr = 1'b0; dat_wr = 1'b0;
   endtask

   task automatic wr_both(input logic [7:0] c, input logic [7:0] d);
      @(posedge clk); #1;
      cmd_wr = 1'b1; cmd_byte = c; dat_wr = 1'b1; dat_byte = d;
      sb.push_back(item(1'b0, c));   // R2: command before data
      sb.push_back(item(1'b1, d));
      @(posedge clk); #1;
      cmd_wr = 1'b0; dat_wr = 1'b0;
   endtask

   task automatic drain();
      int n = 0;
      while (sb.size() != 0 && n < 2000) begin @(posedge clk); n++; end
      repeat (3) @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R8 reset state
      check("R8 out_valid", out_valid, 0);
      check("R8 cmd_full", cmd_full, 0);
      check("R8 dat_full", dat_full, 0);
      check("R8 overflow", overflow, 0);
      check("R8 rle_reject", rle_reject, 0);
      rst_n = 1'b1;

      // interleaved stream, ECP mode
      ready_mode = 1;
      wr(1'b0, 8'h05, 1, 1);
      wr(1'b1, 8'hAA, 1, 1);
      wr(1'b0, 8'h83, 1, 1);
      wr(1'b1, 8'h11, 1, 1);
      wr(1'b1, 8'h22, 1, 1);
      drain();

      // R2 same-cycle writes with stalled output
      ready_mode = 0;
      wr(1'b1, 8'h40, 1, 1);
      wr_both(8'h7F, 8'h41);
      wr_both(8'hC2, 8'h42);
      // R3 hold while stalled
      @(negedge clk);
      check("R3 valid", out_valid, 1);
      check("R3 byte", out_byte, 8'h40);
      repeat (3) @(negedge clk);
      check("R3 byte held", out_byte, 8'h40);
      check("R3 tag held", out_is_data, 1);
      ready_mode = 1;
      drain();

      // R4 refused run-length, R5 channel in other mode
      mode = 3'b000;
      wr(1'b0, 8'h10, 0, 1);
      check("R4 rle_reject pulse", rle_reject, 1);
      @(posedge clk); #1;
      check("R4 rle_reject one cycle", rle_reject, 0);
      check("R4 not presented", out_valid, 0);
      wr(1'b0, 8'h90, 1, 1);           // R5
      wr(1'b1, 8'h33, 1, 1);
      drain();
      check("R4 no overflow", overflow, 0);
      mode = 3'b011;

      // R6 / R7 fill data queue
      ready_mode = 0;
      for (int i = 0; i < 8; i++) wr(1'b1, 8'h60 + 8'(i), 1, 0);
      check("R6 dat_full", dat_full, 1);
      check("R6 cmd_full", cmd_full, 0);
      check("R7 overflow clear", overflow, 0);
      wr(1'b1, 8'hEE, 0, 0);
      check("R7 overflow set", overflow, 1);
      for (int i = 0; i < 8; i++) wr(1'b0, 8'h80 + 8'(i), 1, 0);
      check("R6 cmd_full", cmd_full, 1);
      wr(1'b0, 8'h8F, 0, 0);
      ready_mode = 1;
      drain();
      check("R7 sticky", overflow, 1);
      check("R9 idle", out_valid, 0);

      // stress with random ready
      ready_mode = 2;
      for (int i = 0; i < 60; i++) begin
         if (i % 3 == 0) wr(1'b0, (i % 2 == 0) ? 8'(i) : 8'h80 | 8'(i), 1, 1);
         else            wr(1'b1, 8'hB0 ^ 8'(i), 1, 1);
      end
      drain();
      check("R9 all drained", sb.size(), 0);
      check("R9 idle end", out_valid, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule